// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Receiver

This block listens to a single-wire variable-pulse-width serial bus and turns it into bytes. The raw line is synchronised and de-glitched. The block then times each steady level in microsecond units and names it as a data bit, a frame opener, an end-of-data mark, an end-of-frame mark or a malformed pulse. The value of a bit depends on two things: whether the line was driven (active) or released (passive), and whether the pulse was short or long.

After a frame opener, decoded bits are shifted in most significant bit first. Each finished byte moves to a host-visible holding register, or waits in a second stage when the holding register is still occupied. A further byte that finds both places full flags an overrun and pulses an interrupt. At end of data the frame is judged. It passes only when it holds whole bytes and its final byte is the complement of the CRC-8 of the bytes before it. The host must pulse a configuration strobe once after reset before anything on the line is decoded.

Top module: `vpw_rx`

## Requirements
- R1: After reset `rx_full`, `overrun`, `irq`, `frame_ok`, `frame_err` and `sym_valid` are all low.
- R2: Until the first `cfg_wr` pulse after reset, bus activity produces no symbol, no byte and no frame result.
- R3: `bus_in` (1 = active) passes a two-flop synchroniser and then a filter that follows only a level seen on three consecutive clocks, so a pulse of two clocks or fewer has no effect.
- R4: An active pulse of T µs (one µs = `TICK_DIV` clocks) gives code 5 (bad) when T < 34, code 1 (one) when 34 ≤ T < 96, code 0 (zero) when 96 ≤ T ≤ 163, and code 2 (frame opener) when T > 163.
- R5: A passive pulse shorter than 34 µs gives code 5, one of 34 to 95 µs gives code 0, and one of 96 to 162 µs gives code 1. A passive level reaching 163 µs gives code 3 (end of data) once, and one reaching 239 µs gives code 4 (end of frame) once.
- R6: Bits are shifted only after a frame opener, MSB first. Bit symbols outside a frame produce no byte and no frame result.
- R7: A finished byte goes to `rx_data`/`rx_full` when that register is empty, and otherwise waits in a second stage. A one-clock `rd` pulse while `rx_full` is high consumes `rx_data` and brings the waiting byte forward in arrival order.
- R8: A byte that completes while both stages are full is dropped, sets `overrun` and pulses `irq` for one clock. `overrun` stays high until the next frame opener.
- R9: At end of data `frame_ok` pulses if the bit count is a multiple of 8, at least one byte arrived, and the last byte equals the bitwise inverse of the CRC-8 of the earlier bytes (polynomial 0x1D, initial value 0xFF, MSB first). Otherwise `frame_err` pulses.
- R10: A bad symbol inside a frame ends the frame with a `frame_err` pulse. Later bits up to the next opener are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration strobe that enables decoding |
| bus_in | input | 1 | Raw bus level, 1 = active |
| rd | input | 1 | Host read pulse for the holding register |
| rx_data | output | 8 | Holding register byte |
| rx_full | output | 1 | Holding register holds an unread byte |
| overrun | output | 1 | Sticky overrun status |
| irq | output | 1 | One-clock overrun interrupt |
| frame_ok | output | 1 | One-clock good-frame pulse |
| frame_err | output | 1 | One-clock bad-frame pulse |
| sym_valid | output | 1 | A symbol was classified this clock |
| sym_code | output | 3 | Symbol code (0 zero, 1 one, 2 opener, 3 end of data, 4 end of frame, 5 bad) |

## Verification
The assertions assume that `rd` is pulsed only while `rx_full` is high and that `cfg_wr` is a short strobe. They also assume that every bus level the filter accepts lasts well beyond three clocks, apart from deliberate glitches. The stimulus keeps to this. Reads come from one reader that pulses `rd` on alternate clocks while a byte is held. Every pulse is a whole number of microseconds, with lengths kept at least a few µs away from the class boundaries. The only sub-filter pulses are two-clock glitches.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    typedef enum logic [2:0] {
        SYM_ZERO = 3'd0,
        SYM_ONE  = 3'd1,
        SYM_SOF  = 3'd2,
        SYM_EOD  = 3'd3,
        SYM_EOF  = 3'd4,
        SYM_BAD  = 3'd5
    } sym_e;

    // One byte through the CRC-8 register, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        logic       fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/vpw_rx_filter.sv
module vpw_rx_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    typedef struct packed {
        logic [1:0]          sync;
        logic [FILT_LEN-1:0] hist;
        logic                flt;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], din};
        s_d.hist = {s_q.hist[FILT_LEN-2:0], s_q.sync[1]};
        if (&s_q.hist)       s_d.flt = 1'b1;
        else if (~|s_q.hist) s_d.flt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.flt;

    // R3: the filtered level moves only to a value the whole history agreed on
    a_r3_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flt != $past(s_q.flt)) |->
            ($past(s_q.hist) == {FILT_LEN{s_q.flt}}));

endmodule

// File: rtl/vpw_rx_timer.sv
module vpw_rx_timer
    import vpw_rx_pkg::*;
#(
    parameter int TICK_DIV   = 2,
    parameter int SHORT_US   = 34,
    parameter int LONG_US    = 96,
    parameter int LONGMAX_US = 163,
    parameter int EOF_US     = 239
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level,
    output logic sym_valid,
    output sym_e sym_code
);
    localparam int CW = $clog2(EOF_US + 1);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] T_SHORT = CW'(SHORT_US);
    localparam logic [CW-1:0] T_LONG  = CW'(LONG_US);
    localparam logic [CW-1:0] T_LMAX  = CW'(LONGMAX_US);
    localparam logic [CW-1:0] T_EOF   = CW'(EOF_US);
    localparam logic [PW-1:0] P_LAST  = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
        logic          lvl;
        logic          valid;
        sym_e          code;
    } tmr_t;

    tmr_t s_d, s_q;
    logic got;
    sym_e cls;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        got       = 1'b0;
        cls       = SYM_BAD;
        if (level != s_q.lvl) begin
            // the level that just ended is classified by its length
            s_d.lvl = level;
            s_d.cnt = '0;
            s_d.pre = '0;
            if (s_q.lvl) begin
                got = 1'b1;
                if (s_q.cnt < T_SHORT)      cls = SYM_BAD;
                else if (s_q.cnt < T_LONG)  cls = SYM_ONE;
                else if (s_q.cnt <= T_LMAX) cls = SYM_ZERO;
                else                        cls = SYM_SOF;
            end else if (s_q.cnt < T_LMAX) begin
                got = 1'b1;
                if (s_q.cnt < T_SHORT)      cls = SYM_BAD;
                else if (s_q.cnt < T_LONG)  cls = SYM_ZERO;
                else                        cls = SYM_ONE;
            end
        end else begin
            if (s_q.pre == P_LAST) begin
                s_d.pre = '0;
                if (s_q.cnt != T_EOF) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (!s_q.lvl && (s_d.cnt == T_LMAX)) begin
                        got = 1'b1;
                        cls = SYM_EOD;
                    end else if (!s_q.lvl && (s_d.cnt == T_EOF)) begin
                        got = 1'b1;
                        cls = SYM_EOF;
                    end
                end
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
        if (got && en) begin
            s_d.valid = 1'b1;
            s_d.code  = cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cnt   <= T_EOF;
            s_q.code  <= SYM_BAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign sym_valid = s_q.valid;
    assign sym_code  = s_q.code;

    // R2: no symbol leaves the timer while decoding is disabled
    a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(en));

    // R5: end-of-data and end-of-frame marks only come out of a passive level
    a_r5_marks_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (sym_code == SYM_EOD || sym_code == SYM_EOF)) |-> !s_q.lvl);

endmodule

// File: rtl/vpw_rx_frame.sv
module vpw_rx_frame
    import vpw_rx_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h1D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  sym_e       sym_code,
    input  logic       rd,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       overrun,
    output logic       irq,
    output logic       frame_ok,
    output logic       frame_err
);
    typedef struct packed {
        logic       in_frame;
        logic [7:0] shreg;
        logic [2:0] nbit;
        logic       any_byte;
        logic [7:0] crc;
        logic [7:0] crc_prev;
        logic [7:0] last;
        logic [7:0] hold;
        logic       hold_full;
        logic [7:0] stg;
        logic       stg_full;
        logic       ovr;
        logic       irq;
        logic       ok;
        logic       err;
    } frm_t;

    frm_t       s_d, s_q;
    logic       done;
    logic [7:0] byte_new;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        s_d.ok   = 1'b0;
        s_d.err  = 1'b0;
        done     = 1'b0;
        byte_new = {s_q.shreg[6:0], (sym_code == SYM_ONE)};

        // host read first: consumed byte leaves, waiting byte moves up
        if (rd && s_q.hold_full) begin
            if (s_q.stg_full) begin
                s_d.hold     = s_q.stg;
                s_d.stg_full = 1'b0;
            end else begin
                s_d.hold_full = 1'b0;
            end
        end

        if (sym_valid) begin
            if (sym_code == SYM_SOF) begin
                s_d.in_frame = 1'b1;
                s_d.nbit     = '0;
                s_d.any_byte = 1'b0;
                s_d.crc      = 8'hFF;
                s_d.crc_prev = 8'hFF;
                s_d.ovr      = 1'b0;
            end else if (s_q.in_frame) begin
                if (sym_code == SYM_ZERO || sym_code == SYM_ONE) begin
                    s_d.shreg = byte_new;
                    s_d.nbit  = s_q.nbit + 1'b1;
                    done      = (s_q.nbit == 3'd7);
                end else if (sym_code == SYM_EOD) begin
                    s_d.in_frame = 1'b0;
                    if (s_q.nbit == 3'd0 && s_q.any_byte && (s_q.last == ~s_q.crc_prev))
                        s_d.ok = 1'b1;
                    else
                        s_d.err = 1'b1;
                end else if (sym_code == SYM_BAD) begin
                    s_d.in_frame = 1'b0;
                    s_d.err      = 1'b1;
                end
            end
        end

        if (done) begin
            s_d.any_byte = 1'b1;
            s_d.crc_prev = s_q.crc;
            s_d.crc      = crc8_step(s_q.crc, byte_new, POLY);
            s_d.last     = byte_new;
            if (!s_d.hold_full) begin
                s_d.hold      = byte_new;
                s_d.hold_full = 1'b1;
            end else if (!s_d.stg_full) begin
                s_d.stg      = byte_new;
                s_d.stg_full = 1'b1;
            end else begin
                s_d.ovr = 1'b1;
                s_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_data   = s_q.hold;
    assign rx_full   = s_q.hold_full;
    assign overrun   = s_q.ovr;
    assign irq       = s_q.irq;
    assign frame_ok  = s_q.ok;
    assign frame_err = s_q.err;

    // R7: an unread byte stays put until the host reads it
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd) |=> (rx_full && $stable(rx_data)));

    // R8: the interrupt accompanies a set overrun status
    a_r8_irq_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> overrun);

    // R9: a frame cannot be judged good and bad at once
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_err));

    // R6: a byte appears in the empty holding register only while a frame is open
    a_r6_bytes_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(s_q.in_frame));

endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
    import vpw_rx_pkg::*;
#(
    parameter int         TICK_DIV   = 2,
    parameter int         FILT_LEN   = 3,
    parameter int         SHORT_US   = 34,
    parameter int         LONG_US    = 96,
    parameter int         LONGMAX_US = 163,
    parameter int         EOF_US     = 239,
    parameter logic [7:0] POLY       = 8'h1D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       bus_in,
    input  logic       rd,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       overrun,
    output logic       irq,
    output logic       frame_ok,
    output logic       frame_err,
    output logic       sym_valid,
    output logic [2:0] sym_code
);
    logic en_d, en_q;
    logic level;
    sym_e code;

    always_comb en_d = en_q | cfg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    vpw_rx_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_in),
        .level (level)
    );

    vpw_rx_timer #(
        .TICK_DIV   (TICK_DIV),
        .SHORT_US   (SHORT_US),
        .LONG_US    (LONG_US),
        .LONGMAX_US (LONGMAX_US),
        .EOF_US     (EOF_US)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .level     (level),
        .sym_valid (sym_valid),
        .sym_code  (code)
    );

    assign sym_code = code;

    vpw_rx_frame #(.POLY(POLY)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_code  (code),
        .rd        (rd),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .overrun   (overrun),
        .irq       (irq),
        .frame_ok  (frame_ok),
        .frame_err (frame_err)
    );

    // R2: once enabled, decoding stays enabled
    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

endmodule

// File: tb/vpw_rx_test.sv
module vpw_rx_test;
    localparam int TD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       bus_in = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, irq, frame_ok, frame_err, sym_valid;
    logic [2:0] sym_code;

    int n_checks = 0;
    int n_fail   = 0;
    int n_sym [0:5];
    int n_ok = 0, n_err = 0, n_irq = 0;
    logic       auto_rd = 1'b0;
    logic [7:0] cap [0:63];
    int         cap_n = 0;
    logic [7:0] tx [0:7];
    int         tx_n;

    always #2.5 clk = ~clk;

    vpw_rx uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .bus_in(bus_in), .rd(rd),
        .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun), .irq(irq),
        .frame_ok(frame_ok), .frame_err(frame_err),
        .sym_valid(sym_valid), .sym_code(sym_code)
    );

    initial for (int i = 0; i < 6; i++) n_sym[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sym_valid && sym_code < 3'd6) n_sym[sym_code] = n_sym[sym_code] + 1;
            if (frame_ok)  n_ok++;
            if (frame_err) n_err++;
            if (irq)       n_irq++;
        end
    end

    // single reader: pulses rd on alternate clocks while a byte is held
    always @(negedge clk) begin
        if (auto_rd && rx_full && !rd) begin
            if (cap_n < 64) cap[cap_n] = rx_data;
            cap_n++;
            rd <= 1'b1;
        end else begin
            rd <= 1'b0;
        end
    end

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ tx[i];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
        end
        return c;
    endfunction

    function automatic int ones_in(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += $countones(tx[i]);
        return s;
    endfunction

    task automatic check(input logic cond, input string tag, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic lv, input int us);
        bus_in = lv;
        repeat (us * TD) @(negedge clk);
    endtask

    // sends opener, tx[0..tx_n-1] MSB first, xb extra bits, then a long passive gap
    task automatic send_frame(input int xb, input int sd, input int ld, input logic glitch);
        logic l = 1'b0;
        logic b;
        int   d;
        pulse(1'b1, 200);
        for (int i = 0; i < tx_n * 8 + xb; i++) begin
            b = (i < tx_n * 8) ? tx[i / 8][7 - (i % 8)] : i[0];
            d = (l == 1'b0) ? (b ? ld : sd) : (b ? sd : ld);
            if (glitch && i == 0) begin
                bus_in = 1'b0;
                repeat (40) @(negedge clk);
                bus_in = 1'b1;
                repeat (2) @(negedge clk);
                bus_in = 1'b0;
                repeat (d * TD - 42) @(negedge clk);
            end else begin
                pulse(l, d);
            end
            l = ~l;
        end
        pulse(1'b0, 300);
        repeat (20) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int ok0, err0, cap0, s0, s1, so, sd, sf, sb;
        int sdur, ldur;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!rx_full && !overrun && !irq && !frame_ok && !frame_err && !sym_valid,
              "R1 reset outputs", {rx_full, overrun, irq, frame_ok, frame_err, sym_valid}, 0);

        // R2: a full frame before configuration is ignored
        tx[0] = 8'h5A; tx_n = 1; tx[1] = ~ref_crc(1); tx_n = 2;
        send_frame(0, 64, 128, 1'b0);
        check(n_sym[0] + n_sym[1] + n_sym[2] + n_sym[3] + n_sym[4] + n_sym[5] == 0,
              "R2 no symbols before cfg", n_sym[2], 0);
        check(!rx_full && n_ok == 0 && n_err == 0, "R2 no byte or result before cfg", rx_full, 0);

        cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
        repeat (10) @(negedge clk);

        // R7: two bytes unread fill both stages, no overrun
        tx[0] = 8'hC3; tx_n = 1; tx[1] = ~ref_crc(1); tx_n = 2;
        s0 = n_sym[0]; s1 = n_sym[1]; so = n_sym[2]; sd = n_sym[3]; sf = n_sym[4];
        send_frame(0, 64, 128, 1'b0);
        check(n_ok == 1, "R9 good two-byte frame", n_ok, 1);
        check(rx_full && rx_data == 8'hC3, "R7 first byte held", rx_data, 8'hC3);
        check(!overrun && n_irq == 0, "R8 no overrun with two bytes", overrun, 0);
        check(n_sym[2] - so == 1 && n_sym[3] - sd == 1 && n_sym[4] - sf == 1,
              "R5 one opener, one end of data, one end of frame", n_sym[3] - sd, 1);
        check(n_sym[1] - s1 == ones_in(2) && n_sym[0] - s0 == 16 - ones_in(2),
              "R4 one-symbol count", n_sym[1] - s1, ones_in(2));
        cap0 = cap_n; auto_rd = 1'b1;
        repeat (10) @(negedge clk);
        check(cap_n - cap0 == 2 && cap[cap0] == 8'hC3 && cap[cap0 + 1] == tx[1],
              "R7 bytes read in arrival order", cap[cap0 + 1], tx[1]);
        auto_rd = 1'b0;

        // R8: three unread bytes -> overrun, third dropped
        tx[0] = 8'h81; tx[1] = 8'h7E; tx_n = 2; tx[2] = ~ref_crc(2); tx_n = 3;
        ok0 = n_ok;
        send_frame(0, 64, 128, 1'b0);
        check(overrun == 1'b1, "R8 overrun set", overrun, 1);
        check(n_irq == 1, "R8 single irq pulse", n_irq, 1);
        check(n_ok == ok0 + 1, "R9 crc over all three bytes", n_ok, ok0 + 1);
        cap0 = cap_n; auto_rd = 1'b1;
        repeat (10) @(negedge clk);
        check(cap_n - cap0 == 2 && cap[cap0] == 8'h81 && cap[cap0 + 1] == 8'h7E,
              "R8 third byte dropped", cap_n - cap0, 2);

        // R6: bit symbols with no opener give nothing; overrun survives
        ok0 = n_ok; err0 = n_err; cap0 = cap_n; s1 = n_sym[1];
        pulse(1'b1, 64); pulse(1'b0, 64); pulse(1'b1, 128); pulse(1'b0, 300);
        check(n_sym[1] - s1 == 1 && cap_n == cap0 && n_ok == ok0 && n_err == err0,
              "R6 bits outside frame ignored", cap_n - cap0, 0);
        check(overrun == 1'b1, "R8 overrun held until opener", overrun, 1);

        // R3: glitch inside a passive bit; frame still good, overrun cleared by opener
        tx[0] = 8'h3C; tx_n = 1; tx[1] = ~ref_crc(1); tx_n = 2;
        ok0 = n_ok; cap0 = cap_n;
        send_frame(0, 64, 128, 1'b1);
        check(n_ok == ok0 + 1, "R3 glitch ignored", n_ok, ok0 + 1);
        check(cap_n - cap0 == 2 && cap[cap0] == 8'h3C, "R3 glitch byte value", cap[cap0], 8'h3C);
        check(overrun == 1'b0, "R8 overrun cleared by opener", overrun, 0);

        // R9: bad CRC
        tx[0] = 8'h11; tx[1] = ref_crc(1); tx_n = 2;
        err0 = n_err; ok0 = n_ok;
        send_frame(0, 64, 128, 1'b0);
        check(n_err == err0 + 1 && n_ok == ok0, "R9 wrong crc rejected", n_err - err0, 1);

        // R9: partial byte
        tx[0] = 8'hA5; tx_n = 1; tx[1] = ~ref_crc(1); tx_n = 2;
        err0 = n_err;
        send_frame(4, 64, 128, 1'b0);
        check(n_err == err0 + 1, "R9 bit count not multiple of 8", n_err - err0, 1);

        // R10: bad pulse inside a frame
        err0 = n_err; ok0 = n_ok; sb = n_sym[5];
        pulse(1'b1, 200); pulse(1'b0, 64); pulse(1'b1, 64); pulse(1'b0, 128);
        pulse(1'b1, 20); pulse(1'b0, 64); pulse(1'b1, 64); pulse(1'b0, 300);
        repeat (20) @(negedge clk);
        check(n_sym[5] - sb == 1, "R4 short active pulse is bad", n_sym[5] - sb, 1);
        check(n_err == err0 + 1 && n_ok == ok0, "R10 bad symbol ends frame", n_err - err0, 1);

        // R4 R5 R9: random frames with varied pulse widths
        for (int f = 0; f < 6; f++) begin
            tx_n = 1 + int'($urandom_range(0, 2));
            for (int i = 0; i < tx_n; i++) tx[i] = 8'($urandom());
            tx[tx_n] = ~ref_crc(tx_n);
            tx_n++;
            case ($urandom_range(0, 2))
                0: sdur = 40;
                1: sdur = 64;
                default: sdur = 90;
            endcase
            case ($urandom_range(0, 2))
                0: ldur = 100;
                1: ldur = 128;
                default: ldur = 155;
            endcase
            ok0 = n_ok; cap0 = cap_n; s1 = n_sym[1];
            send_frame(0, sdur, ldur, 1'b0);
            check(n_ok == ok0 + 1, "R9 random frame accepted", n_ok, ok0 + 1);
            check(n_sym[1] - s1 == ones_in(tx_n), "R5 random one-symbol count",
                  n_sym[1] - s1, ones_in(tx_n));
            for (int i = 0; i < tx_n; i++)
                check(cap[cap0 + i] == tx[i], "R6 random byte MSB first", cap[cap0 + i], tx[i]);
        end

        summary();
    end
endmodule